// File: doc/BRIEF.md
# I2C Target Interface with General-Call Reset

This block is the bus-facing side of a small peripheral on a two-wire serial bus. A system clock oversamples the bus clock and data lines. From these samples the block finds start, repeated-start and stop conditions. It then receives an address byte and answers on the ninth clock when the byte names this device. The device address has seven bits: six of them are fixed by a parameter and the lowest one comes from an external select pin.

On a write, the first data byte sets a register pointer and each later byte fills the next register. On a read, the block shifts register contents out, most significant bit first, and steps the pointer after each byte. The bus is open drain. The block never drives a high level: a single output-enable pulls the data line low.

The block also decodes the broadcast software-reset sequence. This is the all-zero address followed by the command byte 0x06. When it sees this sequence, it pulses a reset output and clears its register array.

Top module: `i2c_gc_target`

## Requirements
- R1: After rst_ni is released, sda_oe_o and gc_reset_o are low, and all registers read back as 0x00.
- R2: A START is SDA falling while SCL is high, and it begins address reception from any state. A STOP is SDA rising while SCL is high, and it returns the block to idle with SDA released. A byte clocked without a preceding START is not acknowledged.
- R3: The device address is {ADDR_BASE[6:1], addr_sel_i}. An address byte carries this address in bits 7:1, with R/W in bit 0 (1 = read). When the address matches, the block pulls SDA low through the whole high phase of the ninth clock.
- R4: An address other than the device address or the general-call address 0x00 gets no acknowledge. This includes a 10-bit header 11110xx. The block then ignores the bus until the next START, so later bytes get no acknowledge either.
- R5: In a write, the first data byte loads the pointer from its low log2(NUM_REGS) bits. Each later byte is acknowledged, written to the register at the pointer, and the pointer is incremented.
- R6: In a read, the block sends the register at the pointer MSB first and post-increments the pointer. The pointer wraps from NUM_REGS-1 to 0.
- R7: A controller not-acknowledge on a read byte ends transmission. SDA then stays released, whatever is clocked, until the next START.
- R8: After address byte 0x00 and data byte 0x06, gc_reset_o pulses high for exactly one clock cycle. The pulse comes after the rising SCL edge of the following acknowledge clock, while SCL is still high and the block still holds SDA low. All registers are then cleared to 0x00.
- R9: A general-call data byte other than 0x06 is acknowledged. It produces no pulse and leaves the registers unchanged.
- R10: The general-call address with R/W = 1 (byte 0x01) is not acknowledged.
- R11: A repeated START in the middle of a transfer restarts address reception and keeps the pointer. A write that sets the pointer, followed by a repeated START and a read, returns the register that was pointed to.
- R12: sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_sel_i | input | 1 | Supplies bit 0 of the 7-bit device address |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| gc_reset_o | output | 1 | One-cycle pulse on a general-call software reset |

## Verification
The bound checker checks the following on every cycle:
- a detected START always leads to address reception, and a detected STOP always leads to idle;
- idle never drives SDA;
- the output-enable moves only while the synchronised SCL is low;
- the reset pulse lasts one cycle and falls inside an acknowledge that the block is driving.

Only the bench scenarios can show the following:
- address matching through the select pin;
- rejection of foreign and 10-bit headers;
- pointer loading, auto-increment and wrap-around;
- the end of transmission after a controller not-acknowledge;
- that an unrelated general-call command leaves the registers intact, while 0x06 clears them.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_e;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_WDATA, K_GC} kind_e;
  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [7:0] GC_RESET_CMD = 8'h06;
endpackage

// File: rtl/i2c_gc_sync.sv
module i2c_gc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // conditions need SCL high on both samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_gc_regs.sv
module i2c_gc_regs #(
  parameter int NUM_REGS = 8,
  parameter int AW       = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem[g] <= '0;
      else if (clr_i)                                mem[g] <= '0;
      else if (we_i && waddr_i == AW'(g))            mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2c_gc_target.sv
module i2c_gc_target
  import i2c_gc_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE   = 7'h48,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic addr_sel_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic gc_reset_o
);
  localparam int PW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  st_e   state;
  kind_e kind;
  logic [7:0]    shreg, txreg, rdata;
  logic [2:0]    bitcnt;
  logic          rx_full, is_read, gc_hit, mack_nack, sda_oe_q, gc_pulse_q;
  logic [PW-1:0] ptr, ptr_nxt;
  logic [6:0]    my_addr;
  logic          we;

  i2c_gc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign my_addr = {ADDR_BASE[6:1], addr_sel_i};
  assign ptr_nxt = (ptr == PW'(NUM_REGS - 1)) ? '0 : ptr + 1'b1;
  assign we      = (state == ST_RX) && scl_fall && rx_full && (kind == K_WDATA) && !start_det && !stop_det;

  i2c_gc_regs #(.NUM_REGS(NUM_REGS), .AW(PW)) u_regs (
    .clk_i, .rst_ni, .clr_i(gc_pulse_q), .we_i(we), .waddr_i(ptr),
    .wdata_i(shreg), .raddr_i(ptr), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; kind <= K_ADDR; shreg <= '0; txreg <= '0; bitcnt <= '0;
      rx_full <= 1'b0; is_read <= 1'b0; gc_hit <= 1'b0; mack_nack <= 1'b0;
      sda_oe_q <= 1'b0; gc_pulse_q <= 1'b0; ptr <= '0;
    end else begin
      gc_pulse_q <= 1'b0;
      if (start_det) begin
        state <= ST_RX; kind <= K_ADDR; bitcnt <= '0; rx_full <= 1'b0;
        sda_oe_q <= 1'b0; is_read <= 1'b0; gc_hit <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE; sda_oe_q <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && !rx_full) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) rx_full <= 1'b1;
            end else if (scl_fall && rx_full) begin
              rx_full <= 1'b0;
              bitcnt  <= '0;
              state   <= ST_ACK;
              sda_oe_q <= 1'b1;
              unique case (kind)
                K_ADDR: begin
                  if (shreg[7:1] == my_addr) begin
                    is_read <= shreg[0];
                    kind    <= K_PTR;
                  end else if (shreg == GC_ADDR_BYTE) begin
                    kind <= K_GC;
                  end else begin
                    state    <= ST_IDLE;
                    sda_oe_q <= 1'b0;
                  end
                end
                K_PTR: begin
                  ptr  <= shreg[PW-1:0];
                  kind <= K_WDATA;
                end
                K_WDATA: ptr <= ptr_nxt;
                default: gc_hit <= (shreg == GC_RESET_CMD);
              endcase
            end
          end
          ST_ACK: begin
            if (scl_rise && gc_hit) begin
              gc_pulse_q <= 1'b1;
              gc_hit     <= 1'b0;
            end else if (scl_fall) begin
              if (is_read) begin
                txreg <= rdata; sda_oe_q <= ~rdata[7]; ptr <= ptr_nxt;
                bitcnt <= '0; state <= ST_TX;
              end else begin
                state <= ST_RX; sda_oe_q <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                state <= ST_MACK; sda_oe_q <= 1'b0; bitcnt <= '0;
              end else begin
                txreg    <= {txreg[6:0], 1'b0};
                sda_oe_q <= ~txreg[6];
                bitcnt   <= bitcnt + 3'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) mack_nack <= sda_s;
            else if (scl_fall) begin
              if (mack_nack) state <= ST_IDLE;
              else begin
                txreg <= rdata; sda_oe_q <= ~rdata[7]; ptr <= ptr_nxt;
                bitcnt <= '0; state <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = sda_oe_q;
  assign gc_reset_o = gc_pulse_q;
endmodule

// File: rtl/i2c_gc_checker.sv
module i2c_gc_checker
  import i2c_gc_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input st_e  state,
  input logic sda_oe_o,
  input logic gc_reset_o
);
  AST_START_TO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> state == ST_RX);  // R2
  AST_STOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> state == ST_IDLE);  // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> !sda_oe_o);  // R4
  AST_SDA_MOVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);  // R12
  AST_GC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_reset_o |=> !gc_reset_o);  // R8
  AST_GC_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_reset_o |-> (sda_oe_o && scl_s));  // R8
endmodule

bind i2c_gc_target i2c_gc_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .state(state), .sda_oe_o(sda_oe_o), .gc_reset_o(gc_reset_o)
);

// File: tb/i2c_gc_target_test.sv
module i2c_gc_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [6:0] BASE = 7'h48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, gc_rst;
  wire  sda_line = sda_m & ~sda_oe;

  int total = 0, bad = 0;
  int pulses = 0, oe_hi_cnt = 0, oe_bad_moves = 0;
  logic pulse_scl = 1'b0, pulse_sda = 1'b1, prev_oe = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_gc_target uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_sel_i(addr_sel), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .gc_reset_o(gc_rst)
  );

  always @(posedge clk) begin
    if (gc_rst) begin pulses <= pulses + 1; pulse_scl <= scl; pulse_sda <= sda_line; end
    if (sda_oe) oe_hi_cnt <= oe_hi_cnt + 1;
    if (rst_n && sda_oe != prev_oe && scl) oe_bad_moves <= oe_bad_moves + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(); scl = 1'b1; hw(); sda_m = 1'b0; hw(); scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(); scl = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(); scl = 1'b1; hw(); hw(); scl = 1'b0; hw();
    end
    sda_m = 1'b1; hw(); scl = 1'b1; hw();
    ack = ~sda_line;
    hw(); scl = 1'b0; hw();
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); scl = 1'b1; hw(); b[i] = sda_line; hw(); scl = 1'b0;
    end
    hw(); sda_m = nack; hw(); scl = 1'b1; hw(); hw(); scl = 1'b0; hw(); sda_m = 1'b1;
  endtask

  task automatic write_reg(input logic [7:0] p, input logic [7:0] d, output int acks);
    logic a;
    acks = 0;
    bus_start();
    send_byte({BASE[6:1], addr_sel, 1'b0}, a); acks += int'(a);
    send_byte(p, a); acks += int'(a);
    send_byte(d, a); acks += int'(a);
    bus_stop();
  endtask

  task automatic read_reg(input logic [7:0] p, output logic [7:0] d, output int acks);
    logic a;
    acks = 0;
    bus_start();
    send_byte({BASE[6:1], addr_sel, 1'b0}, a); acks += int'(a);
    send_byte(p, a); acks += int'(a);
    bus_start();
    send_byte({BASE[6:1], addr_sel, 1'b1}, a); acks += int'(a);
    read_byte(1'b1, d);
    bus_stop();
  endtask

  // {addr_sel, pointer, data}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'h00, 8'hA5}, {1'b1, 8'h01, 8'h3C}, {1'b0, 8'h05, 8'hFF},
    {1'b1, 8'h07, 8'h81}, {1'b0, 8'h02, 8'h00}, {1'b1, 8'h04, 8'h5A}
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a, a2;
    logic [7:0] d;
    int acks;
    repeat (5) @(negedge clk);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 gc_reset after reset", int'(gc_rst), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    read_reg(8'h03, d, acks);
    chk("R1 register reset value", int'(d), 8'h00);

    foreach (VEC[i]) begin
      addr_sel = VEC[i][16];
      write_reg(VEC[i][15:8], VEC[i][7:0], acks);
      chk("R3 R5 write acks", acks, 3);
      read_reg(VEC[i][15:8], d, acks);
      chk("R11 readback acks", acks, 3);
      chk("R6 R11 readback data", int'(d), int'(VEC[i][7:0]));
    end

    // R4: wrong select bit, then following byte
    addr_sel = 1'b0;
    bus_start();
    send_byte({BASE[6:1], 1'b1, 1'b0}, a);
    send_byte(8'h55, a2);
    bus_stop();
    chk("R4 foreign address nack", int'(a), 0);
    chk("R4 byte after foreign address", int'(a2), 0);
    bus_start();
    send_byte(8'hF0, a);
    bus_stop();
    chk("R4 10-bit header nack", int'(a), 0);

    // R6: wrap 7 -> 0 -> 1 (reg7=81, reg0=A5, reg1=3C)
    bus_start();
    send_byte({BASE[6:1], addr_sel, 1'b0}, a);
    send_byte(8'h07, a);
    bus_start();
    send_byte({BASE[6:1], addr_sel, 1'b1}, a);
    read_byte(1'b0, d); chk("R6 read reg7", int'(d), 8'h81);
    read_byte(1'b0, d); chk("R6 wrap to reg0", int'(d), 8'hA5);
    read_byte(1'b1, d); chk("R6 then reg1", int'(d), 8'h3C);
    // R7: keep clocking after controller NACK
    oe_hi_cnt = 0;
    for (int i = 0; i < 18; i++) begin hw(); scl = 1'b1; hw(); scl = 1'b0; end
    hw();
    chk("R7 sda released after nack", oe_hi_cnt, 0);
    bus_stop();

    // R2: byte with no START is ignored
    send_byte({BASE[6:1], addr_sel, 1'b0}, a);
    chk("R2 byte without start", int'(a), 0);
    bus_stop();
    chk("R2 released after stop", int'(sda_oe), 0);

    // R10
    bus_start();
    send_byte(8'h01, a);
    bus_stop();
    chk("R10 general call read nack", int'(a), 0);

    // R9: other general-call command
    bus_start();
    send_byte(8'h00, a);
    send_byte(8'h07, a2);
    bus_stop();
    chk("R9 gc addr ack", int'(a), 1);
    chk("R9 other cmd ack", int'(a2), 1);
    chk("R9 no pulse", pulses, 0);
    read_reg(8'h00, d, acks);
    chk("R9 registers kept", int'(d), 8'hA5);

    // R8: software reset
    bus_start();
    send_byte(8'h00, a);
    send_byte(8'h06, a2);
    chk("R8 reset cmd ack", int'(a2), 1);
    chk("R8 one pulse", pulses, 1);
    chk("R8 pulse while SCL high", int'(pulse_scl), 1);
    chk("R8 pulse while ack driven", int'(pulse_sda), 0);
    bus_stop();
    read_reg(8'h00, d, acks);
    chk("R8 reg0 cleared", int'(d), 8'h00);
    read_reg(8'h07, d, acks);
    chk("R8 reg7 cleared", int'(d), 8'h00);
    chk("R8 still one pulse", pulses, 1);

    chk("R12 sda_oe moves only with SCL low", oe_bad_moves, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule